// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a network controller's DMA engine. A MAC hands it received frames one byte at a time, each frame's last byte flagged together with that frame's CRC-error and framing-error verdicts. The block places the bytes into host memory buffers. Each buffer is described by a four-word (16-bit) descriptor in a ring that both the host and the device own in turn. For every frame the block reads the descriptor at its current ring position. If the device owns it, the block streams the bytes into the buffer. When the frame ends, it writes the message length and hands the descriptor back to the host with a status flag byte.

A frame longer than one buffer continues in the next descriptor that the device owns. Only the final descriptor of the frame carries the end-of-frame mark, the length and the error bits. When the ring position is host-owned at the start of a frame, the frame is dropped and a missed-frame event pulses. When it is host-owned partway through a frame, the buffer being filled is closed with overflow status and the rest of the frame is discarded. A small internal byte queue absorbs the MAC's bytes while descriptor words are being fetched or written back.

Descriptor word layout, byte offsets from the descriptor start: word 0 (+0) holds buffer address bits 15:0. Word 1 (+2) holds buffer address bits 23:16 in bits 7:0 and the flag byte in bits 15:8. Word 2 (+4) holds the buffer size, negated. Word 3 (+6) holds the message length. Descriptor i lives at ring base + 8·i. The memory port is 16 bits wide and byte-addressed. A word at an even address A keeps byte A in bits 7:0 and byte A+1 in bits 15:8. Read data returns in the cycle after a read request.

Top module: `rdr_rx_ring_writer`

## Requirements
- R1: Each frame's bytes are written, in arrival order, to consecutive byte addresses starting at the buffer address {word1[7:0], word0}. They go to the descriptor at the current ring position, provided that descriptor's flag bit 7 (ownership, 1 = device) is set.
- R2: The buffer size is the two's-complement negation of word 2, whose bits 15:12 the host sets. A buffer takes exactly that many bytes before the frame spills to another descriptor.
- R3: A frame that fits in one buffer with no error leaves that descriptor's flag byte at exactly 0x03 (bit 1 start, bit 0 end, bit 7 ownership cleared) and word 3 equal to the byte count, CRC included, with bits 15:12 zero.
- R4: A frame that overruns its buffer continues in the next ring descriptor when the device owns it. Every non-final descriptor is released with bit 0 clear, with bit 1 set only on the first, and with word 3 left untouched. The final descriptor gets bit 0 and word 3 equal to the whole frame length.
- R5: On the final descriptor, a MAC CRC error sets flag bit 3 and a framing error sets bit 5. Bit 6 is the OR of bits 2, 3, 4 and 5 of the same flag byte.
- R6: Word 3 of a final descriptor is written in the memory cycle just before its flag byte is released.
- R7: The ring position advances after each released descriptor and wraps modulo 2^cfg_ring_log2.
- R8: If the descriptor at the ring position is host-owned when a frame starts, ev_missed pulses for one cycle. No memory write takes place for that frame, and the ring position does not change.
- R9: If a buffer is full, more bytes follow and the next descriptor is host-owned, the current descriptor is released with flag bits 2 (buffer error), 4 (overflow) and 6 set, bit 1 as in R4 and bit 0 clear. The rest of the frame is discarded without memory writes, no rx event is raised, and the ring position moves past the released descriptor.
- R10: irq_rx pulses for one cycle once for each descriptor released with bit 0 set, and at no other time.
- R11: While rst_n is low, and afterwards until a byte arrives, no memory request is made and both events stay low.
- R12: A read and a write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_ring_lo | input | 16 | Ring base address bits 15:0 |
| cfg_ring_hi | input | 8 | Ring base address bits 23:16 |
| cfg_ring_log2 | input | 3 | log2 of the number of ring descriptors |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | This byte ends the frame |
| rx_crc_err | input | 1 | CRC verdict, valid with rx_last |
| rx_frame_err | input | 1 | Framing verdict, valid with rx_last |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 24 | Byte address of the access |
| mem_be | output | 2 | Byte lanes written (bit 0 = even byte) |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after mem_rd |
| irq_rx | output | 1 | One-cycle pulse per completed-frame descriptor release |
| ev_missed | output | 1 | One-cycle pulse per frame dropped at its start |

## Verification
The bound assertions watch every cycle for the ordering and form of descriptor hand-back. A released flag byte never keeps ownership, and its error-summary bit always equals the OR of its error bits. An end-marked release always follows the length write to the same descriptor, and an rx event follows only an end-marked release. A missed-frame pulse is never accompanied by a write, and no read and write coincide. Buffer placement, the spill from one descriptor to the next, exact-fit buffers, ring wrap, the unchanged ring position after a miss and the overflow close-out all depend on what host memory holds. Only the bench's directed and random frames show them, by comparing memory against a model of the ring.

// File: rtl/rdr_pkg.sv
// Shared constants and types for the receive descriptor ring writer.
// Assumes 24-bit host addresses and 16-bit descriptor words.
package rdr_pkg;
    localparam int ADDR_W     = 24;
    localparam int LEN_W      = 12;
    localparam int SIZE_W     = 13;
    localparam int LOG2_W     = 3;
    localparam int IDX_W      = (1 << LOG2_W) - 1;

    // Flag byte bit positions; the host decodes these.
    localparam int FL_END  = 0;
    localparam int FL_STA  = 1;
    localparam int FL_BUF  = 2;
    localparam int FL_CRC  = 3;
    localparam int FL_OVF  = 4;
    localparam int FL_FRM  = 5;
    localparam int FL_ERR  = 6;
    localparam int FL_DEV  = 7;

    // Descriptor word byte offsets.
    localparam logic [ADDR_W-1:0] OFS_BASE = 24'd0;
    localparam logic [ADDR_W-1:0] OFS_FLAG = 24'd2;
    localparam logic [ADDR_W-1:0] OFS_SIZE = 24'd4;
    localparam logic [ADDR_W-1:0] OFS_LEN  = 24'd6;

    typedef enum logic [3:0] {
        S_IDLE, S_F1, S_F2, S_F3, S_F4, S_WBC,
        S_DATA, S_LEN, S_FLAG, S_OVF, S_DISC
    } wr_state_t;

    typedef struct packed {
        logic       fram;
        logic       crc;
        logic       last;
        logic [7:0] data;
    } rx_ent_t;
endpackage

// File: rtl/rdr_byte_fifo.sv
// Small synchronous queue between the MAC byte stream and the DMA engine.
// Assumes DEPTH is a power of two; a push into a full queue is dropped.
module rdr_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PW = $clog2(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PW:0]      wr_p;
    logic [PW:0]      rd_p;

    assign empty = (wr_p == rd_p);
    assign full  = (wr_p[PW] != rd_p[PW]) && (wr_p[PW-1:0] == rd_p[PW-1:0]);
    assign dout  = store[rd_p[PW-1:0]];

    // Pointer update on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_p <= '0;
            rd_p <= '0;
        end else begin
            if (push && !full) wr_p <= wr_p + 1'b1;
            if (pop && !empty) rd_p <= rd_p + 1'b1;
        end
    end

    // Entry storage, written without reset.
    always_ff @(posedge clk) begin
        if (push && !full) store[wr_p[PW-1:0]] <= din;
    end
endmodule

// File: rtl/rdr_ring_step.sv
// Next ring position, wrapping modulo 2**log2.
// Assumes the current index is already inside the ring.
module rdr_ring_step
    import rdr_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic [LOG2_W-1:0] log2,
    output logic [IDX_W-1:0]  next_idx
);
    logic [IDX_W-1:0] mask;

    // Mask from log2, then advance with wrap.
    always_comb begin
        mask     = IDX_W'((32'd1 << log2) - 32'd1);
        next_idx = (idx + 1'b1) & mask;
    end
endmodule

// File: rtl/rdr_desc_addr.sv
// Byte address of a descriptor: ring base plus eight bytes per entry.
// Assumes the ring does not cross the top of the address space.
module rdr_desc_addr
    import rdr_pkg::*;
(
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] desc
);
    // Scale the index by the descriptor size.
    always_comb desc = ring_base + ADDR_W'({idx, 3'b000});
endmodule

// File: rtl/rdr_flag_pack.sv
// Builds a released flag byte; ownership is always cleared and the
// summary bit is the OR of the four error bits.
module rdr_flag_pack
    import rdr_pkg::*;
(
    input  logic       fin,
    input  logic       sta,
    input  logic       buf_e,
    input  logic       crc_e,
    input  logic       ovf_e,
    input  logic       frm_e,
    output logic [7:0] flag
);
    // Place each status bit at its fixed position.
    always_comb begin
        flag         = '0;
        flag[FL_END] = fin;
        flag[FL_STA] = sta;
        flag[FL_BUF] = buf_e;
        flag[FL_CRC] = crc_e;
        flag[FL_OVF] = ovf_e;
        flag[FL_FRM] = frm_e;
        flag[FL_ERR] = buf_e | crc_e | ovf_e | frm_e;
        flag[FL_DEV] = 1'b0;
    end
endmodule

// File: rtl/rdr_rx_ring_writer.sv
// Receive DMA back end: moves MAC bytes into host buffers named by a ring of
// four-word descriptors, chaining across buffers and handing each descriptor
// back with length and status. Assumes memory read data one cycle after a
// read, and a MAC byte rate the internal queue can absorb during fetches.
module rdr_rx_ring_writer
    import rdr_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        cfg_ring_lo,
    input  logic [7:0]         cfg_ring_hi,
    input  logic [LOG2_W-1:0]  cfg_ring_log2,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    input  logic               rx_last,
    input  logic               rx_crc_err,
    input  logic               rx_frame_err,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [1:0]         mem_be,
    output logic [15:0]        mem_wdata,
    input  logic [15:0]        mem_rdata,
    output logic               irq_rx,
    output logic               ev_missed
);
    localparam int ENT_W = $bits(rx_ent_t);

    wr_state_t          state;
    logic [IDX_W-1:0]   cur_idx;
    logic [IDX_W-1:0]   fetch_idx;
    logic [IDX_W-1:0]   cur_next;
    logic [ADDR_W-1:0]  ring_base;
    logic [ADDR_W-1:0]  desc_of [2];
    logic [IDX_W-1:0]   idx_of  [2];
    logic [ADDR_W-1:0]  cur_desc;
    logic [ADDR_W-1:0]  fetch_desc;
    logic [7:0]         base_hi;
    logic [ADDR_W-1:0]  buf_ptr;
    logic [SIZE_W-1:0]  buf_size;
    logic [SIZE_W-1:0]  buf_cnt;
    logic [LEN_W-1:0]   frame_len;
    logic               chain;
    logic               first_buf;
    logic               err_crc;
    logic               err_fram;
    logic               irq_q;
    logic               miss_q;

    logic [ENT_W-1:0]   f_in_v;
    logic [ENT_W-1:0]   f_out_v;
    rx_ent_t            f_out;
    logic               f_empty;
    logic               f_full;
    logic               f_pop;
    logic               buf_full;
    logic               take_byte;
    logic [ADDR_W-1:0]  byte_addr;

    logic               pk_fin, pk_sta, pk_buf, pk_crc, pk_ovf, pk_frm;
    logic [7:0]         flag_byte;
    logic               flag_wr;
    logic               len_wr;

    assign ring_base = {cfg_ring_hi, cfg_ring_lo};
    assign irq_rx    = irq_q;
    assign ev_missed = miss_q;

    // Byte queue between the MAC and the DMA engine.
    assign f_in_v = {rx_frame_err, rx_crc_err, rx_last, rx_data};
    assign f_out  = rx_ent_t'(f_out_v);

    rdr_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENT_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_valid),
        .din   (f_in_v),
        .pop   (f_pop),
        .dout  (f_out_v),
        .empty (f_empty),
        .full  (f_full)
    );

    rdr_ring_step u_step (
        .idx      (cur_idx),
        .log2     (cfg_ring_log2),
        .next_idx (cur_next)
    );

    // Descriptor addresses for the buffer being filled and the one probed.
    assign idx_of[0] = cur_idx;
    assign idx_of[1] = fetch_idx;

    for (genvar g = 0; g < 2; g++) begin : g_desc
        rdr_desc_addr u_addr (
            .ring_base (ring_base),
            .idx       (idx_of[g]),
            .desc      (desc_of[g])
        );
    end

    assign cur_desc   = desc_of[0];
    assign fetch_desc = desc_of[1];

    assign buf_full  = (buf_cnt == buf_size);
    assign take_byte = (state == S_DATA) && !f_empty && !buf_full;
    assign f_pop     = take_byte || ((state == S_DISC) && !f_empty);
    assign byte_addr = buf_ptr + ADDR_W'(buf_cnt);

    // Status inputs for the flag byte, chosen by the release kind.
    always_comb begin
        pk_fin = 1'b0;
        pk_sta = 1'b0;
        pk_buf = 1'b0;
        pk_crc = 1'b0;
        pk_ovf = 1'b0;
        pk_frm = 1'b0;
        case (state)
            S_WBC: pk_sta = first_buf;
            S_FLAG: begin
                pk_fin = 1'b1;
                pk_sta = first_buf;
                pk_crc = err_crc;
                pk_frm = err_fram;
            end
            S_OVF: begin
                pk_sta = first_buf;
                pk_buf = 1'b1;
                pk_ovf = 1'b1;
            end
            default: ;
        endcase
    end

    rdr_flag_pack u_flag (
        .fin   (pk_fin),
        .sta   (pk_sta),
        .buf_e (pk_buf),
        .crc_e (pk_crc),
        .ovf_e (pk_ovf),
        .frm_e (pk_frm),
        .flag  (flag_byte)
    );

    // Memory request for the current state.
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_be    = 2'b00;
        mem_wdata = '0;
        flag_wr   = 1'b0;
        len_wr    = 1'b0;
        case (state)
            S_F1: begin
                mem_rd   = 1'b1;
                mem_addr = fetch_desc + OFS_FLAG;
            end
            S_F2: begin
                mem_rd   = 1'b1;
                mem_addr = fetch_desc + OFS_SIZE;
            end
            S_F3: begin
                mem_rd   = 1'b1;
                mem_addr = fetch_desc + OFS_BASE;
            end
            S_WBC, S_FLAG, S_OVF: begin
                mem_wr    = 1'b1;
                flag_wr   = 1'b1;
                mem_addr  = cur_desc + OFS_FLAG;
                mem_be    = 2'b10;
                mem_wdata = {flag_byte, 8'h00};
            end
            S_LEN: begin
                mem_wr    = 1'b1;
                len_wr    = 1'b1;
                mem_addr  = cur_desc + OFS_LEN;
                mem_be    = 2'b11;
                mem_wdata = {{(16 - LEN_W){1'b0}}, frame_len};
            end
            S_DATA: begin
                if (take_byte) begin
                    mem_wr    = 1'b1;
                    mem_addr  = byte_addr;
                    mem_be    = byte_addr[0] ? 2'b10 : 2'b01;
                    mem_wdata = {f_out.data, f_out.data};
                end
            end
            default: ;
        endcase
    end

    // Frame sequencing: fetch, fill, chain, close, drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cur_idx   <= '0;
            fetch_idx <= '0;
            base_hi   <= '0;
            buf_ptr   <= '0;
            buf_size  <= '0;
            buf_cnt   <= '0;
            frame_len <= '0;
            chain     <= 1'b0;
            first_buf <= 1'b0;
            err_crc   <= 1'b0;
            err_fram  <= 1'b0;
            irq_q     <= 1'b0;
            miss_q    <= 1'b0;
        end else begin
            irq_q  <= 1'b0;
            miss_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (!f_empty) begin
                        fetch_idx <= cur_idx;
                        chain     <= 1'b0;
                        first_buf <= 1'b1;
                        frame_len <= '0;
                        state     <= S_F1;
                    end
                end
                S_F1: state <= S_F2;
                S_F2: begin
                    if (mem_rdata[8 + FL_DEV]) begin
                        base_hi <= mem_rdata[7:0];
                        state   <= S_F3;
                    end else if (chain) begin
                        state <= S_OVF;
                    end else begin
                        miss_q <= 1'b1;
                        state  <= S_DISC;
                    end
                end
                S_F3: begin
                    buf_size <= (~mem_rdata[SIZE_W-1:0]) + 1'b1;
                    state    <= S_F4;
                end
                S_F4: begin
                    buf_ptr <= {base_hi, mem_rdata};
                    buf_cnt <= '0;
                    state   <= chain ? S_WBC : S_DATA;
                end
                S_WBC: begin
                    first_buf <= 1'b0;
                    cur_idx   <= fetch_idx;
                    state     <= S_DATA;
                end
                S_DATA: begin
                    if (!f_empty) begin
                        if (buf_full) begin
                            fetch_idx <= cur_next;
                            chain     <= 1'b1;
                            state     <= S_F1;
                        end else begin
                            buf_cnt   <= buf_cnt + 1'b1;
                            frame_len <= frame_len + 1'b1;
                            if (f_out.last) begin
                                err_crc  <= f_out.crc;
                                err_fram <= f_out.fram;
                                state    <= S_LEN;
                            end
                        end
                    end
                end
                S_LEN: state <= S_FLAG;
                S_FLAG: begin
                    irq_q   <= 1'b1;
                    cur_idx <= cur_next;
                    state   <= S_IDLE;
                end
                S_OVF: begin
                    cur_idx <= fetch_idx;
                    state   <= S_DISC;
                end
                S_DISC: begin
                    if (!f_empty && f_out.last) state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rdr_rx_ring_writer_chk.sv
// Protocol checks on the ring writer's memory port and events.
// Attached to every instance of the top module by the bind below.
module rdr_rx_ring_writer_chk
    import rdr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_be,
    input logic [15:0]       mem_wdata,
    input logic              irq_rx,
    input logic              ev_missed,
    input logic              flag_wr,
    input logic              len_wr
);
    // R3: a released flag byte never keeps device ownership.
    p_own_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |-> (mem_wr && !mem_wdata[15] && mem_be == 2'b10));

    // R3: the length word carries zeros above bit 11.
    p_len_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        len_wr |-> (mem_wdata[15:12] == 4'h0 && mem_be == 2'b11));

    // R5: summary bit equals the OR of the four error bits.
    p_err_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |-> (mem_wdata[14] == (|mem_wdata[13:10])));

    // R6: an end-marked release follows the length write to the same descriptor.
    p_len_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && mem_wdata[8]) |->
            ($past(len_wr) && $past(mem_addr) == mem_addr + 24'd4));

    // R9: an overflow close-out never carries the end mark.
    p_ovf_no_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && mem_wdata[12]) |-> !mem_wdata[8]);

    // R10: an rx event follows only an end-marked release.
    p_irq_after_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> $past(flag_wr && mem_wdata[8]));

    // R8: a missed frame is not accompanied by a write.
    p_missed_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_missed |-> !mem_wr);

    // R12: one memory operation per cycle.
    p_one_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

bind rdr_rx_ring_writer rdr_rx_ring_writer_chk u_chk (.*);

// File: tb/sim_rdr_rx_ring_writer.sv
// Bench: host memory model, directed corner frames, then seeded random frames.
module sim_rdr_rx_ring_writer;
    localparam int RING  = 32'h0100;
    localparam int BUFB  = 32'h1000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cfg_ring_lo;
    logic [7:0]  cfg_ring_hi;
    logic [2:0]  cfg_ring_log2;
    logic        rx_valid, rx_last, rx_crc_err, rx_frame_err;
    logic [7:0]  rx_data;
    logic        mem_rd, mem_wr;
    logic [23:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata, mem_rdata;
    logic        irq_rx, ev_missed;

    logic [15:0] mem [4096];
    logic [7:0]  fb [512];
    int n_chk = 0, n_fail = 0;
    int n_irq = 0, n_miss = 0, n_wr = 0, r6_bad = 0, r12_bad = 0;
    logic [23:0] last_addr = '0;
    logic [1:0]  last_be = '0;
    int exp_idx = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rdr_rx_ring_writer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_ring_lo(cfg_ring_lo), .cfg_ring_hi(cfg_ring_hi),
        .cfg_ring_log2(cfg_ring_log2), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_crc_err(rx_crc_err), .rx_frame_err(rx_frame_err),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_rx(irq_rx), .ev_missed(ev_missed)
    );

    // Host memory: one-cycle read latency, byte-lane writes; plus port monitors.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[12:1]];
        if (mem_wr) begin
            if (mem_be[0]) mem[mem_addr[12:1]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) mem[mem_addr[12:1]][15:8] <= mem_wdata[15:8];
            n_wr <= n_wr + 1;
            if (mem_addr >= 24'(RING) && mem_addr < 24'(RING + 64) &&
                mem_addr[2:0] == 3'd2 && mem_be == 2'b10 && mem_wdata[8] &&
                !(last_addr == mem_addr + 24'd4 && last_be == 2'b11))
                r6_bad <= r6_bad + 1;
            last_addr <= mem_addr;
            last_be   <= mem_be;
        end
        if (mem_rd && mem_wr) r12_bad <= r12_bad + 1;
        if (rst_n && irq_rx) n_irq <= n_irq + 1;
        if (rst_n && ev_missed) n_miss <= n_miss + 1;
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_byte(input int a);
        logic [15:0] w;
        w = mem[(a >> 1) & 12'hFFF];
        return ((a & 1) != 0) ? w[15:8] : w[7:0];
    endfunction

    task automatic arm(input int idx, input int size);
        int dw;
        dw = (RING >> 1) + idx * 4;
        mem[dw]     = 16'(BUFB + idx * 256);
        mem[dw + 1] = 16'h8000;
        mem[dw + 2] = 16'(17'h10000 - 17'(size));
        mem[dw + 3] = 16'h0000;
    endtask

    task automatic send(input int len, input bit crc, input bit fram);
        for (int b = 0; b < len; b++) begin
            @(negedge clk);
            fb[b]        = 8'($urandom);
            rx_valid     = 1'b1;
            rx_data      = fb[b];
            rx_last      = (b == len - 1);
            rx_crc_err   = (b == len - 1) && crc;
            rx_frame_err = (b == len - 1) && fram;
            @(negedge clk);
            rx_valid = 1'b0; rx_last = 1'b0; rx_crc_err = 1'b0; rx_frame_err = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (40) @(negedge clk);
    endtask

    // Model of one completed frame over all-owned descriptors of equal size.
    task automatic expect_frame(input string tag, input int start, input int len,
                                input int size, input int ring_n,
                                input bit crc, input bit fram);
        int n, bad, idx, dw, cnt;
        logic [7:0] ef;
        n = (len + size - 1) / size;
        bad = 0;
        for (int j = 0; j < n; j++) begin
            idx = (start + j) % ring_n;
            dw  = (RING >> 1) + idx * 4;
            ef  = 8'h00;
            if (j == 0) ef[1] = 1'b1;
            if (j == n - 1) begin
                ef[0] = 1'b1; ef[3] = crc; ef[5] = fram; ef[6] = crc | fram;
            end
            check_eq({tag, " flag word"}, int'(mem[dw + 1]), int'({ef, 8'h00}));
            check_eq({tag, " length word"}, int'(mem[dw + 3]), (j == n - 1) ? len : 0);
            cnt = (j == n - 1) ? (len - j * size) : size;
            for (int k = 0; k < cnt; k++)
                if (rd_byte(BUFB + idx * 256 + k) != fb[j * size + k]) bad++;
        end
        check_eq({tag, " R1 data bytes mismatched"}, bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int i0, m0, w0, sz, ln;
        bit ce, fe;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; rx_valid = 0; rx_data = 0; rx_last = 0; rx_crc_err = 0; rx_frame_err = 0;
        cfg_ring_lo = 16'(RING); cfg_ring_hi = 8'h00; cfg_ring_log2 = 3'd2;
        for (int a = 0; a < 4096; a++) mem[a] = 16'h0000;
        for (int d = 0; d < 4; d++) arm(d, 64);
        repeat (3) @(negedge clk);
        check_eq("R11 reset mem requests", int'({mem_rd, mem_wr}), 0);
        check_eq("R11 reset events", int'({irq_rx, ev_missed}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_eq("R11 idle writes", n_wr, 0);

        // R3 single good frame.
        i0 = n_irq; send(40, 0, 0);
        expect_frame("R3 single", 0, 40, 64, 4, 0, 0);
        check_eq("R10 irq per frame", n_irq - i0, 1);
        // R2 exact fit in buffer.
        send(64, 0, 0);
        expect_frame("R2 exact fit", 1, 64, 64, 4, 0, 0);
        // R4 spill across two descriptors, ending on the last ring slot.
        i0 = n_irq; send(100, 0, 0);
        expect_frame("R4 spill", 2, 100, 64, 4, 0, 0);
        check_eq("R10 one irq for spilled frame", n_irq - i0, 1);
        // R7 wrap to slot 0.
        for (int d = 0; d < 4; d++) arm(d, 64);
        send(30, 1, 0);
        expect_frame("R7 wrap R5 crc", 0, 30, 64, 4, 1, 0);
        send(30, 0, 1);
        expect_frame("R5 framing", 1, 30, 64, 4, 0, 1);
        // R8 missed frame at a host-owned slot.
        mem[(RING >> 1) + 2 * 4 + 1] = 16'h0000;
        m0 = n_miss; w0 = n_wr; i0 = n_irq;
        send(20, 0, 0);
        check_eq("R8 missed pulse", n_miss - m0, 1);
        check_eq("R8 no writes", n_wr - w0, 0);
        check_eq("R8 no irq", n_irq - i0, 0);
        arm(2, 64);
        send(20, 0, 0);
        expect_frame("R8 index kept", 2, 20, 64, 4, 0, 0);
        // R9 overflow into host-owned slot 0 from slot 3.
        w0 = n_wr; i0 = n_irq;
        send(100, 0, 0);
        check_eq("R9 overflow flag", int'(mem[(RING >> 1) + 3 * 4 + 1]), 16'h5600);
        check_eq("R9 length untouched", int'(mem[(RING >> 1) + 3 * 4 + 3]), 0);
        check_eq("R9 writes 64 bytes plus flag", n_wr - w0, 65);
        check_eq("R9 no irq", n_irq - i0, 0);
        m0 = n_miss;
        send(10, 0, 0);
        check_eq("R9 index moved to host slot", n_miss - m0, 1);

        // Random frames on an 8-entry ring.
        cfg_ring_log2 = 3'd3;
        exp_idx = 0;
        for (int t = 0; t < 30; t++) begin
            sz = 16 * (1 + ($urandom % 4));
            ln = 1 + ($urandom % (sz * 7));
            ce = (($urandom % 4) == 0);
            fe = (($urandom % 4) == 0);
            for (int d = 0; d < 8; d++) arm(d, sz);
            i0 = n_irq;
            send(ln, ce, fe);
            expect_frame("R4 R7 random", exp_idx, ln, sz, 8, ce, fe);
            check_eq("R10 random irq", n_irq - i0, 1);
            exp_idx = (exp_idx + (ln + sz - 1) / sz) % 8;
        end

        check_eq("R6 length before end release", r6_bad, 0);
        check_eq("R12 read and write together", r12_bad, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule